// File: doc/BRIEF.md
# Keyboard Scan Register Interface

This block keeps a small key matrix image of six 16-bit words and lets a processor read it through a simple 16-bit register bus that covers a 32-byte window. A key source outside the block reports each key event as a word index, a bit mask and two modifier flags (shift and control). The event is parked in a one-entry pending slot. On the next periodic scan tick the image is refreshed: the words are released (cleared) unless a hold flag asks for one more tick, and then the pending event is merged in, so a newly reported key is always visible for at least one full tick interval.

Every tick that finds a key in the image, or that merges a pending event, marks a key change by setting the detect and complete bits of a three-bit interrupt status register. An event that arrives while the pending slot is still full is dropped and sets the lost bit. Software clears status bits by writing ones to them. One level interrupt output follows whether any status bit is set.

Top module: `keyscan_if`

## Requirements
- R1: While rst_n is low, and right after it rises, all six data words read 0, the status register reads 0 and irq_o is low.
- R2: Data word k (k = 0..5) reads at byte offset 2*k; the status register reads at offset 0x18 in bits [2:0] with zeros above. Reads of every other offset, odd offsets included, return 0.
- R3: A key event (key_valid high with key_word 0..5) does not change the data words when it is taken; it is ORed into word key_word at the next scan tick, after that tick's release, and is readable from the cycle after the tick.
- R4: A scan tick with the hold flag clear releases all six words to 0 (apart from any pending event merged on the same tick).
- R5: A pending event with key_shift sets bit 11 (0x0800) of word 5, with key_ctrl sets bit 2 (0x0004) of word 5, and either flag sets the hold flag when merged; the next tick then keeps all words and clears the hold flag, and the tick after that releases them.
- R6: A tick that finds any word nonzero before its release, or that merges a pending event, sets status bits 0 (detect) and 1 (complete); a tick with an empty image and no pending event leaves the status unchanged.
- R7: A key event taken while the pending slot is full and no tick occurs in the same cycle is dropped and sets status bit 2 (lost); on a tick cycle the slot is handed over and a new event is accepted.
- R8: A bus write to offset 0x18 clears exactly the status bits that are 1 in bus_wdata[2:0]; a bit set by the block in the same cycle stays set.
- R9: irq_o is high exactly when the status register is nonzero, changing in the same cycle the status becomes readable.
- R10: Bus writes to the data word offsets and to the soft-reset (0x1A), scan-mode (0x14) and scan-repeat (0x16) offsets change neither the data words nor the status.
- R11: A key event with key_word 6 or 7 is ignored: it neither fills the pending slot nor sets the lost bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle periodic scan strobe |
| key_valid | input | 1 | Key event strobe |
| key_word | input | 3 | Index of the data word the event targets |
| key_mask | input | 16 | Bits to set in the addressed word |
| key_shift | input | 1 | Event carries the shift modifier |
| key_ctrl | input | 1 | Event carries the control modifier |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset inside the 32-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench builds the block with its default parameters: six 16-bit words, which leaves a 3-bit word index with two unused codes, and the modifier word placed at the last index. That makes the out-of-range indices 6 and 7 drivable from the port, puts the modifier bits in the same word as ordinary keys so merging and holding can be seen together, and lets a full sweep of the 16 even offsets cover both mapped and unmapped addresses.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int WIN_ADDR_W = 5;
  localparam int STAT_W     = 3;

  // status bit positions
  localparam int ST_DETECT = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_LOST   = 2;

  // register offsets in the 32-byte window
  localparam logic [WIN_ADDR_W-1:0] OFS_SCAN_MODE = 5'h14;
  localparam logic [WIN_ADDR_W-1:0] OFS_SCAN_REP  = 5'h16;
  localparam logic [WIN_ADDR_W-1:0] OFS_STATUS    = 5'h18;
  localparam logic [WIN_ADDR_W-1:0] OFS_SOFT_RST  = 5'h1A;
endpackage

// File: rtl/keyscan_matrix.sv
module keyscan_matrix #(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 16,
  parameter int MOD_WORD  = 5,
  parameter int SHIFT_BIT = 11,
  parameter int CTRL_BIT  = 2,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              scan_tick,
  input  logic                              key_valid,
  input  logic [IDX_W-1:0]                  key_word,
  input  logic [WORD_W-1:0]                 key_mask,
  input  logic                              key_shift,
  input  logic                              key_ctrl,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
  output logic                              change,
  output logic                              lost
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q, words_d;
  logic                             hold_q, hold_d;
  logic                             pv_q, pv_d;
  logic [IDX_W-1:0]                 pidx_q, pidx_d;
  logic [WORD_W-1:0]                pmask_q, pmask_d;
  logic                             psh_q, psh_d, pct_q, pct_d;
  logic                             in_range;

  assign in_range = (int'(key_word) < NUM_WORDS);

  always_comb begin
    words_d = words_q;
    hold_d  = hold_q;
    pv_d    = pv_q;
    pidx_d  = pidx_q;
    pmask_d = pmask_q;
    psh_d   = psh_q;
    pct_d   = pct_q;
    change  = 1'b0;
    lost    = 1'b0;
    if (scan_tick) begin
      change = (|words_q) | pv_q;
      if (hold_q) hold_d = 1'b0;
      else        words_d = '0;
      if (pv_q) begin
        for (int k = 0; k < NUM_WORDS; k++)
          if (pidx_q == IDX_W'(k)) words_d[k] = words_d[k] | pmask_q;
        if (psh_q) words_d[MOD_WORD][SHIFT_BIT] = 1'b1;
        if (pct_q) words_d[MOD_WORD][CTRL_BIT]  = 1'b1;
        if (psh_q | pct_q) hold_d = 1'b1;
      end
      pv_d = 1'b0;
    end
    if (key_valid && in_range) begin
      if (!pv_q || scan_tick) begin
        pv_d    = 1'b1;
        pidx_d  = key_word;
        pmask_d = key_mask;
        psh_d   = key_shift;
        pct_d   = key_ctrl;
      end else begin
        lost = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      hold_q  <= 1'b0;
      pv_q    <= 1'b0;
      pidx_q  <= '0;
      pmask_q <= '0;
      psh_q   <= 1'b0;
      pct_q   <= 1'b0;
    end else begin
      words_q <= words_d;
      hold_q  <= hold_d;
      pv_q    <= pv_d;
      pidx_q  <= pidx_d;
      pmask_q <= pmask_d;
      psh_q   <= psh_d;
      pct_q   <= pct_d;
    end
  end

  assign words = words_q;
endmodule

// File: rtl/keyscan_stat.sv
module keyscan_stat
  import keyscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              change,
  input  logic              lost,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [STAT_W-1:0] stat_q, stat_d, set_v;
  logic              irq_q, irq_d, irq_en;

  always_comb begin
    set_v            = '0;
    set_v[ST_DETECT] = change;
    set_v[ST_DONE]   = change;
    set_v[ST_LOST]   = lost;
    stat_d           = (stat_q & ~clr) | set_v;
    irq_d            = |stat_d;
    irq_en           = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;
endmodule

// File: rtl/keyscan_regbus.sv
module keyscan_regbus
  import keyscan_pkg::*;
#(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 16
) (
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic [WIN_ADDR_W-1:0]             bus_addr,
  input  logic [WORD_W-1:0]                 bus_wdata,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
  input  logic [STAT_W-1:0]                 stat,
  output logic [WORD_W-1:0]                 bus_rdata,
  output logic [STAT_W-1:0]                 clr
);
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[WORD_W-1:STAT_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == OFS_STATUS) begin
        bus_rdata[STAT_W-1:0] = stat;
      end else if (!bus_addr[0]) begin
        for (int k = 0; k < NUM_WORDS; k++)
          if (bus_addr[WIN_ADDR_W-1:1] == (WIN_ADDR_W-1)'(k)) bus_rdata = words[k];
      end
    end
  end

  always_comb begin
    clr = '0;
    if (bus_sel && bus_wr && bus_addr == OFS_STATUS) clr = bus_wdata[STAT_W-1:0];
  end
endmodule

// File: rtl/keyscan_if.sv
module keyscan_if
  import keyscan_pkg::*;
#(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 16,
  parameter int MOD_WORD  = 5,
  parameter int SHIFT_BIT = 11,
  parameter int CTRL_BIT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_tick,
  input  logic                          key_valid,
  input  logic [$clog2(NUM_WORDS)-1:0]  key_word,
  input  logic [WORD_W-1:0]             key_mask,
  input  logic                          key_shift,
  input  logic                          key_ctrl,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [WIN_ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic                          irq_o
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0][WORD_W-1:0] words_w;
  logic                             change_w, lost_w;
  logic [STAT_W-1:0]                stat_w, clr_w;

  keyscan_matrix #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .MOD_WORD(MOD_WORD),
    .SHIFT_BIT(SHIFT_BIT), .CTRL_BIT(CTRL_BIT), .IDX_W(IDX_W)
  ) matrix_i (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .key_valid(key_valid), .key_word(key_word), .key_mask(key_mask),
    .key_shift(key_shift), .key_ctrl(key_ctrl),
    .words(words_w), .change(change_w), .lost(lost_w)
  );

  keyscan_stat stat_i (
    .clk(clk), .rst_n(rst_n), .change(change_w), .lost(lost_w),
    .clr(clr_w), .stat(stat_w), .irq(irq_o)
  );

  keyscan_regbus #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) regbus_i (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .words(words_w), .stat(stat_w),
    .bus_rdata(bus_rdata), .clr(clr_w)
  );
endmodule

// File: rtl/keyscan_if_chk.sv
module keyscan_if_chk
  import keyscan_pkg::*;
#(
  parameter int NUM_WORDS = 6,
  parameter int WORD_W    = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             scan_tick,
  input logic                             key_valid,
  input logic                             bus_sel,
  input logic                             bus_wr,
  input logic [WIN_ADDR_W-1:0]            bus_addr,
  input logic [WORD_W-1:0]                bus_rdata,
  input logic                             irq_o,
  input logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  input logic [STAT_W-1:0]                stat
);
  AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_STATUS) |-> (irq_o == (bus_rdata[STAT_W-1:0] != '0))); // R9

  AST_WORDS_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scan_tick) |-> $stable(words)); // R3

  AST_DETECT_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_DETECT]) |-> $past(scan_tick)); // R6

  AST_DETECT_DONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_DONE]) |-> stat[ST_DETECT]); // R6

  AST_LOST_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_LOST]) |-> $past(key_valid)); // R7
endmodule

bind keyscan_if keyscan_if_chk #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_valid(key_valid),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .words(words_w), .stat(stat_w)
);

// File: tb/keyscan_if_tb_top.sv
`timescale 1ns/1ps
module keyscan_if_tb_top;
  logic        clk;
  logic        rst_n;
  logic        scan_tick, key_valid, key_shift, key_ctrl;
  logic [2:0]  key_word;
  logic [15:0] key_mask;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  event  smp_ev;

  keyscan_if dut_i (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_valid(key_valid),
    .key_word(key_word), .key_mask(key_mask), .key_shift(key_shift),
    .key_ctrl(key_ctrl), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // monitor: pops expected items and compares against the ports
  always @(smp_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {15'd0, irq_o} : bus_rdata;
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", it.req, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [4:0] a, input logic [15:0] e, input string r);
    item_t it;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.is_irq = 0; it.exp = e; it.req = r;
    sb_q.push_back(it);
    #1 -> smp_ev;
    #0.5 bus_sel = 0;
  endtask

  task automatic exp_irq(input bit e, input string r);
    item_t it;
    it.is_irq = 1; it.exp = {15'd0, e}; it.req = r;
    sb_q.push_back(it);
    #1 -> smp_ev;
  endtask

  // one clock with given strobes; inputs change at falling edges
  task automatic step(input bit tk, input bit kv, input logic [2:0] w,
                      input logic [15:0] m, input bit sh, input bit ct,
                      input bit wr, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    scan_tick = tk; key_valid = kv; key_word = w; key_mask = m;
    key_shift = sh; key_ctrl = ct;
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    scan_tick = 0; key_valid = 0; key_shift = 0; key_ctrl = 0;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic tick();                 step(1,0,0,0,0,0,0,0,0); endtask
  task automatic ev(input logic [2:0] w, input logic [15:0] m, input bit sh, input bit ct);
    step(0,1,w,m,sh,ct,0,0,0);
  endtask
  task automatic wr(input logic [4:0] a, input logic [15:0] d); step(0,0,0,0,0,0,1,a,d); endtask

  initial begin
    scan_tick = 0; key_valid = 0; key_word = 0; key_mask = 0;
    key_shift = 0; key_ctrl = 0; bus_sel = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    exp_irq(0, "R1 irq in reset");
    rst_n = 1;
    @(negedge clk);
    // R1 / R2: reset state and full even-offset sweep
    for (int k = 0; k < 16; k++) exp_rd(5'(2*k), 16'h0000, "R1 reset read");
    exp_irq(0, "R1 irq after reset");

    // R3: event parked, merged at next tick
    ev(3'd2, 16'h0400, 0, 0);
    exp_rd(5'h04, 16'h0000, "R3 word2 before tick");
    tick();
    exp_rd(5'h04, 16'h0400, "R3 word2 after tick");
    exp_rd(5'h05, 16'h0000, "R2 odd offset");
    exp_rd(5'h18, 16'h0003, "R6 status after merge");
    exp_irq(1, "R9 irq set");
    // R8: write-one-to-clear of one bit, then the other
    wr(5'h18, 16'h0001);
    exp_rd(5'h18, 16'h0002, "R8 partial clear");
    exp_irq(1, "R9 irq still set");
    wr(5'h18, 16'hFFFE);
    exp_rd(5'h18, 16'h0000, "R8 full clear");
    exp_irq(0, "R9 irq cleared");
    // R10: writes to data and ignored offsets
    wr(5'h04, 16'h1234); wr(5'h14, 16'hFFFF); wr(5'h16, 16'hFFFF); wr(5'h1A, 16'hFFFF);
    exp_rd(5'h04, 16'h0400, "R10 word2 unchanged");
    exp_rd(5'h18, 16'h0000, "R10 status unchanged");
    exp_rd(5'h14, 16'h0000, "R2 scan-mode reads zero");
    // R4 / R6: release tick flags change
    tick();
    exp_rd(5'h04, 16'h0000, "R4 word2 released");
    exp_rd(5'h18, 16'h0003, "R6 status on release");
    wr(5'h18, 16'h0007);
    tick();
    exp_rd(5'h18, 16'h0000, "R6 empty tick no change");
    exp_irq(0, "R9 irq low after empty tick");

    // R5: shift modifier with hold
    ev(3'd1, 16'h8000, 1, 0);
    tick();
    exp_rd(5'h02, 16'h8000, "R5 word1 merged");
    exp_rd(5'h0A, 16'h0800, "R5 shift bit");
    tick();
    exp_rd(5'h02, 16'h8000, "R5 word1 held");
    exp_rd(5'h0A, 16'h0800, "R5 shift held");
    tick();
    exp_rd(5'h02, 16'h0000, "R5 word1 released");
    exp_rd(5'h0A, 16'h0000, "R5 word5 released");
    // R5: control modifier merged into word 5 next to an ordinary key
    ev(3'd5, 16'h0100, 0, 1);
    tick();
    exp_rd(5'h0A, 16'h0104, "R5 ctrl bit");
    tick();
    exp_rd(5'h0A, 16'h0104, "R5 ctrl held");
    tick();
    exp_rd(5'h0A, 16'h0000, "R5 ctrl released");
    wr(5'h18, 16'h0007);

    // R7: collision drops second event
    ev(3'd0, 16'h0001, 0, 0);
    ev(3'd3, 16'h0002, 0, 0);
    exp_rd(5'h18, 16'h0004, "R7 lost bit");
    exp_irq(1, "R9 irq on lost");
    tick();
    exp_rd(5'h00, 16'h0001, "R7 first event kept");
    exp_rd(5'h06, 16'h0000, "R7 second event dropped");
    // R7: event on tick cycle is accepted while slot hands over
    wr(5'h18, 16'h0007);
    ev(3'd4, 16'h0010, 0, 0);
    step(1,1,3'd0,16'h0020,0,0,0,0,0);
    exp_rd(5'h08, 16'h0010, "R7 handover first");
    exp_rd(5'h18, 16'h0003, "R7 no loss on tick");
    tick();
    exp_rd(5'h00, 16'h0020, "R7 handover second");
    exp_rd(5'h08, 16'h0000, "R4 word4 released");
    tick();
    wr(5'h18, 16'h0007);

    // R11: out-of-range index ignored
    ev(3'd6, 16'hFFFF, 0, 0);
    ev(3'd7, 16'hFFFF, 0, 0);
    exp_rd(5'h18, 16'h0000, "R11 no lost bit");
    tick();
    exp_rd(5'h18, 16'h0000, "R11 no change");
    for (int k = 0; k < 6; k++) exp_rd(5'(2*k), 16'h0000, "R11 words empty");

    // R8: set wins over same-cycle clear
    ev(3'd0, 16'h0008, 0, 0);
    step(1,0,3'd0,16'h0,0,0,1,5'h18,16'h0003);
    exp_rd(5'h18, 16'h0003, "R8 set wins");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    #10;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule